// File: doc/BRIEF.md
# Full-Page Burst Read Path with Stop and Precharge Deadline

This block models the read side of one bank of a synchronous DRAM running column bursts in full-page mode. A read command carries a start column. From then on the block issues one data word per clock from consecutive columns of a 256-column page. The first word reaches the data output a fixed number of clocks after the command: two or three, chosen at reset. The column counter wraps modulo the page size, so a burst has no natural end. It runs until a stop command arrives.

After a stop, the words already issued still drain to the output. The drain lasts exactly as many clocks as the configured latency. After that the output enable drops, and the data lines read zero, which stands for high impedance. A stop also starts a deadline window. If no precharge command arrives within a configurable number of clocks, a sticky error flag is raised. The page contents live in an internal register array that is filled with a fixed pattern at reset. A controller model or a test harness uses the block as a cycle-accurate stand-in for the bank's read timing.

Top module: `fp_burst_reader`

## Requirements
- R1: With latency 2 selected, the word for the start column is presented with `dq_oe` high in the second clock after the clock edge that samples the read command (`cmd` = 1). It is visible right after edge k+1 when the read was sampled at edge k.
- R2: With latency 3 selected (`cas_lat_cfg` = 3 at reset), the first word is visible right after edge k+2.
- R3: While a burst runs, each clock presents the next column. The word for column c is {c XOR 8'hA5, c}, upper byte first.
- R4: The column after 255 is 0. A burst longer than 256 words revisits the start column and continues upward.
- R5: A stop command (`cmd` = 2) sampled at edge s ends issuing. The last valid word is visible after edge s+latency-2, and `dq_oe` is low from edge s+latency-1 onward. A burst stopped L clocks after its read therefore delivers exactly L words.
- R6: After reset, `dq_oe` and `pre_err` are low. Whenever `dq_oe` is low, `dq_out` is zero.
- R7: The latency setting is sampled only during reset. Any value other than 3 selects latency 2, and later changes of `cas_lat_cfg` have no effect.
- R8: If a stop ends an active burst at edge s and no precharge (`cmd` = 3) is sampled at edges s+1 through s+PRE_LIMIT, then `pre_err` rises right after edge s+PRE_LIMIT. A precharge at or before that edge prevents the error.
- R9: Once set, `pre_err` stays high, including through later precharges, until reset.
- R10: A read sampled during an active burst restarts it at the new column with full latency. Words already issued are still delivered in order.
- R11: A stop sampled while no burst is active has no effect: no output appears and no deadline starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; latency is sampled while low |
| cas_lat_cfg | input | 2 | Latency select: 3 gives latency 3, anything else gives 2 |
| cmd | input | 2 | 0 idle, 1 read, 2 stop, 3 precharge |
| col_in | input | COL_W | Start column, used with a read |
| dq_out | output | DATA_W | Read data; zero when not enabled |
| dq_oe | output | 1 | Data output enable; low means high impedance |
| pre_err | output | 1 | Sticky flag: precharge deadline missed |

## Verification
Outputs are sampled at the falling edge, so every value seen reflects the state after the preceding rising edge. The read command is taken as edge 0. A word with burst index n is then due after edge n+latency-1, and the enable must fall after edge stop+latency-1. The vector loop derives each expected value from these offsets for every cycle of the burst and its drain. The deadline flag is due exactly after edge stop+PRE_LIMIT. The directed test checks it one edge earlier, to confirm it is still low, and at that edge, to confirm it has risen.

// File: rtl/fp_burst_reader.sv
module fp_burst_reader #(
  parameter int DATA_W    = 16,
  parameter int COL_W     = 8,
  parameter int PRE_LIMIT = 8,
  localparam int PAGE     = 1 << COL_W,
  localparam int TMR_W    = $clog2(PRE_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cas_lat_cfg,
  input  logic [1:0]        cmd,
  input  logic [COL_W-1:0]  col_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              pre_err
);

  localparam logic [1:0] CMD_NOP  = 2'd0;
  localparam logic [1:0] CMD_READ = 2'd1;
  localparam logic [1:0] CMD_STOP = 2'd2;
  localparam logic [1:0] CMD_PRE  = 2'd3;

  logic [DATA_W-1:0] page_q [PAGE];
  logic              cl3_q;
  logic              active_q;
  logic [COL_W-1:0]  cnt_q;
  logic [2:0]        v_q;
  logic [DATA_W-1:0] d_q [3];
  logic              pend_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              err_q;

  logic              is_read, is_stop, issue_v;
  logic [COL_W-1:0]  issue_col;

  assign is_read   = (cmd == CMD_READ);
  assign is_stop   = (cmd == CMD_STOP) && active_q;
  assign issue_v   = is_read || (active_q && !is_stop);
  assign issue_col = is_read ? col_in : cnt_q;

  // page contents: fixed pattern loaded at reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE; i++)
        page_q[i] <= DATA_W'({COL_W'(i) ^ COL_W'(8'hA5), COL_W'(i)});
    end
  end

  // burst counter and latency pipeline
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cl3_q    <= (cas_lat_cfg == 2'd3);
      active_q <= 1'b0;
      cnt_q    <= '0;
      v_q      <= '0;
      for (int i = 0; i < 3; i++) d_q[i] <= '0;
    end else begin
      active_q <= is_read || (active_q && cmd != CMD_STOP);
      if (issue_v) cnt_q <= issue_col + COL_W'(1);
      v_q    <= {v_q[1:0], issue_v};
      d_q[0] <= issue_v ? page_q[issue_col] : '0;
      d_q[1] <= d_q[0];
      d_q[2] <= d_q[1];
    end
  end

  // precharge deadline after a stop
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tmr_q  <= '0;
      err_q  <= 1'b0;
    end else if (is_stop) begin
      pend_q <= 1'b1;
      tmr_q  <= TMR_W'(PRE_LIMIT);
    end else if (pend_q) begin
      if (cmd == CMD_PRE) begin
        pend_q <= 1'b0;
      end else if (tmr_q == TMR_W'(1)) begin
        pend_q <= 1'b0;
        err_q  <= 1'b1;
      end else begin
        tmr_q <= tmr_q - TMR_W'(1);
      end
    end
  end

  assign dq_oe   = cl3_q ? v_q[2] : v_q[1];
  assign dq_out  = cl3_q ? d_q[2] : d_q[1];
  assign pre_err = err_q;

  p_first_cl2_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_READ && !cl3_q) |=> ##1 dq_oe);

  p_first_cl3_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_READ && cl3_q) |=> ##2 dq_oe);

  // R3 and R4: counter steps by one, wrapping modulo the page
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cmd == CMD_NOP) |=> (cnt_q == $past(cnt_q) + COL_W'(1)));

  p_drain_cl2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STOP && !cl3_q) |=> ##1 !dq_oe);

  p_drain_cl3_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STOP && cl3_q) |=> ##2 !dq_oe);

  p_cl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cl3_q));

  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pre_err) |-> ($past(pend_q) && $past(cmd) != CMD_PRE));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pre_err |=> pre_err);

endmodule

// File: tb/fp_burst_reader_tb.sv
`timescale 1ns/1ps
module fp_burst_reader_tb;
  localparam int LIMIT = 8;
  localparam int NV    = 6;
  // fields: [17] latency-3 select, [16:9] start column, [8:0] clocks from read to stop
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 8'd0,   9'd5},
    {1'b1, 8'd17,  9'd6},
    {1'b0, 8'd250, 9'd12},
    {1'b1, 8'd255, 9'd3},
    {1'b0, 8'd4,   9'd260},
    {1'b1, 8'd128, 9'd1}
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] cas_lat_cfg = 2'd2, cmd = 2'd0;
  logic [7:0] col_in = '0;
  logic [15:0] dq_out;
  logic dq_oe, pre_err;
  int n_chk = 0, n_bad = 0;

  fp_burst_reader u_dut (.clk(clk), .rst_n(rst_n), .cas_lat_cfg(cas_lat_cfg), .cmd(cmd),
                         .col_in(col_in), .dq_out(dq_out), .dq_oe(dq_oe), .pre_err(pre_err));

  always #5 clk = ~clk;

  function automatic logic [15:0] word(input logic [7:0] c);
    return {c ^ 8'hA5, c};
  endfunction

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [1:0] cfg);
    rst_n = 0; cas_lat_cfg = cfg; cmd = 2'd0;
    tick; tick;
    rst_n = 1;
  endtask

  task automatic run_vec(input logic c3, input logic [7:0] col, input int len);
    int lat = c3 ? 3 : 2;
    do_reset(c3 ? 2'd3 : 2'd2);
    for (int j = 0; j <= len + lat + 1; j++) begin
      if (j == 0) begin cmd = 2'd1; col_in = col; end
      else cmd = (j == len) ? 2'd2 : 2'd0;
      tick;
      begin
        int n = j - lat + 1;
        logic vld = (n >= 0) && (n < len);
        logic [7:0] c = 8'(col + n);
        string tag = (n >= len) ? "R5" : (col + n > 255) ? "R4" : (n > 0) ? "R3" : c3 ? "R2" : "R1";
        check(tag, {15'd0, dq_oe, dq_out}, {15'd0, vld, vld ? word(c) : 16'd0});
      end
    end
    cmd = 2'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R6: reset state
    do_reset(2'd2);
    check("R6", {30'd0, dq_oe, pre_err}, 32'd0);
    check("R6", {16'd0, dq_out}, 32'd0);

    for (int v = 0; v < NV; v++) run_vec(VEC[v][17], VEC[v][16:9], int'(VEC[v][8:0]));

    // R7: cfg=1 means latency 2; later change to 3 ignored
    do_reset(2'd1);
    cas_lat_cfg = 2'd3;
    cmd = 2'd1; col_in = 8'd40; tick;
    cmd = 2'd0; tick;
    check("R7", {15'd0, dq_oe, dq_out}, {15'd0, 1'b1, word(8'd40)});
    tick;
    check("R7", {15'd0, dq_oe, dq_out}, {15'd0, 1'b1, word(8'd41)});

    // R10: restart during active burst, latency 3
    do_reset(2'd3);
    cmd = 2'd1; col_in = 8'd10; tick;        // edge 0
    cmd = 2'd0; tick; tick;                  // edges 1,2
    check("R10", {16'd0, dq_out}, {16'd0, word(8'd10)});
    cmd = 2'd1; col_in = 8'd200; tick;       // edge 3
    cmd = 2'd0;
    check("R10", {16'd0, dq_out}, {16'd0, word(8'd11)});
    tick; check("R10", {16'd0, dq_out}, {16'd0, word(8'd12)});
    tick; check("R10", {15'd0, dq_oe, dq_out}, {15'd0, 1'b1, word(8'd200)});
    tick; check("R10", {16'd0, dq_out}, {16'd0, word(8'd201)});

    // R8: deadline missed, R9: sticky
    do_reset(2'd2);
    cmd = 2'd1; col_in = 8'd0; tick;
    cmd = 2'd2; tick;                        // stop at edge s
    cmd = 2'd0;
    for (int m = 1; m < LIMIT; m++) tick;
    check("R8", {31'd0, pre_err}, 32'd0);
    tick;
    check("R8", {31'd0, pre_err}, 32'd1);
    cmd = 2'd3; tick; cmd = 2'd0; tick; tick;
    check("R9", {31'd0, pre_err}, 32'd1);
    do_reset(2'd2);
    check("R9", {31'd0, pre_err}, 32'd0);

    // R8: precharge exactly at the last allowed edge
    cmd = 2'd1; col_in = 8'd3; tick;
    cmd = 2'd2; tick;
    cmd = 2'd0;
    for (int m = 1; m < LIMIT; m++) tick;
    cmd = 2'd3; tick;
    cmd = 2'd0;
    repeat (5) tick;
    check("R8", {31'd0, pre_err}, 32'd0);

    // R11: stop while idle
    do_reset(2'd2);
    cmd = 2'd2; tick;
    cmd = 2'd0;
    repeat (LIMIT + 4) tick;
    check("R11", {30'd0, dq_oe, pre_err}, 32'd0);
    check("R11", {16'd0, dq_out}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule